// File: doc/BRIEF.md
# Multi-Pool Buffer Pointer Manager

This block holds free buffer pointers in a set of independent pools. A requester hands a pointer back to a pool with a release, and it takes a pointer out of a pool with an acquire. Each operation gets a response one cycle later. The response carries a success bit and, for a good acquire, the pointer. Pointers are opaque values: the block stores them and returns them bit for bit. It never checks what they refer to.

Each pool keeps a fill count and has two depletion monitors. The replenish monitor tells software or a refill engine to top the pool up. The flow-control monitor tells upstream senders to pause so that no traffic is lost. Each monitor has an entry level and a higher exit level, so its output does not chatter while the count wobbles around one value. A configuration port sets each pool's capacity and its four levels, but a write only takes effect while that pool is idle.

Top module: `bufpool_mgr`

## Requirements
- R1: After reset every pool is empty, the capacity of each pool is POOL_SLOTS, no response is valid, and both depletion flags of every pool are high with the default levels (replenish enter 4 / exit 8, flow-control enter 2 / exit 4).
- R2: A release into a pool with room answers rspOk=1 with rspIsRelease=1. Acquires from that pool then return the stored pointers unchanged, newest first (last-in first-out), with rspOk=1 and rspIsRelease=0.
- R3: An acquire from an empty pool answers rspOk=0 with rspPtr=0 and leaves the pool count unchanged.
- R4: A release into a pool whose count equals its capacity answers rspOk=0, and the pointer is dropped: the next acquire returns the pointer released before it.
- R5: A pool's replenish flag rises when the count is below its replenish entry level. Once high, it falls only when the count is at or above its replenish exit level. The flag follows a count change one cycle after the response.
- R6: A pool's flow-control flag follows the same hysteresis rule with its own entry and exit levels, independently of the replenish flag.
- R7: At most one operation is taken per cycle. When a release and an acquire arrive together, the release is served, acqAccept is low in that cycle, and no acquire response is produced.
- R8: An operation on one pool changes neither the contents nor the flags of any other pool.
- R9: A configuration write takes effect only if the target pool holds zero pointers and no operation addresses that pool in the same cycle. Otherwise it is ignored.
- R10: A capacity value written above POOL_SLOTS is limited to POOL_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| relValid | input | 1 | Release request |
| relPool | input | POOL_W | Pool addressed by the release |
| relPtr | input | PTR_W | Pointer being released |
| acqValid | input | 1 | Acquire request |
| acqPool | input | POOL_W | Pool addressed by the acquire |
| acqAccept | output | 1 | Acquire taken this cycle (low while a release is present) |
| cfgValid | input | 1 | Configuration write strobe |
| cfgPool | input | POOL_W | Pool being configured |
| cfgCap | input | CNT_W | New capacity |
| cfgReplOn | input | CNT_W | Replenish entry level |
| cfgReplOff | input | CNT_W | Replenish exit level |
| cfgFlowOn | input | CNT_W | Flow-control entry level |
| cfgFlowOff | input | CNT_W | Flow-control exit level |
| rspValid | output | 1 | Response valid, one cycle after an accepted operation |
| rspIsRelease | output | 1 | 1 = response to a release, 0 = to an acquire |
| rspOk | output | 1 | Operation succeeded |
| rspPool | output | POOL_W | Pool of the answered operation |
| rspPtr | output | PTR_W | Acquired pointer, zero otherwise |
| replenish | output | NUM_POOLS | Per-pool replenish request flags |
| flowCtrl | output | NUM_POOLS | Per-pool flow-control flags |

## Verification
A wrong fill count shows up at the ports in two ways. It makes the flags switch at the wrong point in a fill or drain sweep one cycle later. It also makes an acquire return the wrong pointer, or fail too early or too late, in the very next response. The tests therefore walk pools through full fill and drain sequences and check both flags after every step. They push pools against their configured and clamped capacities and then drain them, so a lost or duplicated stack entry shows up as a wrong pointer order. A configuration write that wrongly takes effect is exposed because the capacity or levels it would have set are checked through later releases and flag values.

// File: rtl/bufpool_pkg.sv
package bufpool_pkg;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic opValid;   // some request was taken this cycle
    logic isRel;     // the taken request is a release
    logic push;      // release that fits: store pointer
    logic pop;       // acquire from a non-empty pool
    logic cfgApply;  // configuration write is committed
  } bufpool_strobe_t;

endpackage

// File: rtl/bufpool_hyst.sv
module bufpool_hyst #(
  parameter int CNT_W = 5,
  parameter bit INIT  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] enterLvl,
  input  logic [CNT_W-1:0] exitLvl,
  output logic             flag
);

  logic flagNext;

  always_comb begin
    if (flag) flagNext = (count < exitLvl);
    else      flagNext = (count < enterLvl);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flag <= INIT;
    else       flag <= flagNext;
  end

  // R5 / R6: the flag only enters below the entry level
  a_r5_r6_enter: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> ($past(count) < $past(enterLvl)));

  // R5 / R6: the flag only leaves at or above the exit level
  a_r5_r6_leave: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> ($past(count) >= $past(exitLvl)));

endmodule

// File: rtl/bufpool_ctrl.sv
module bufpool_ctrl
  import bufpool_pkg::*;
#(
  parameter int POOL_W = 6,
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 5
) (
  input  logic              relValid,
  input  logic [POOL_W-1:0] relPool,
  input  logic [PTR_W-1:0]  relPtr,
  input  logic              acqValid,
  input  logic [POOL_W-1:0] acqPool,
  input  logic              cfgValid,
  input  logic [POOL_W-1:0] cfgPool,
  input  logic [CNT_W-1:0]  selCount,
  input  logic [CNT_W-1:0]  selCap,
  input  logic [CNT_W-1:0]  cfgCount,
  output bufpool_strobe_t   stb,
  output logic [POOL_W-1:0] opPool,
  output logic [PTR_W-1:0]  opPtr,
  output logic              acqAccept
);

  logic relWins;
  logic hasRoom;
  logic hasData;
  logic cfgClash;

  // Fixed arbitration: a release always beats an acquire.
  assign relWins   = relValid;
  assign acqAccept = acqValid && !relWins;
  assign opPool    = relWins ? relPool : acqPool;
  assign opPtr     = relPtr;

  assign hasRoom   = (selCount < selCap);
  assign hasData   = (selCount != '0);
  assign cfgClash  = (relValid || acqValid) && (opPool == cfgPool);

  always_comb begin
    stb          = '0;
    stb.opValid  = relValid || acqValid;
    stb.isRel    = relWins;
    stb.push     = relWins && hasRoom;
    stb.pop      = acqAccept && hasData;
    stb.cfgApply = cfgValid && (cfgCount == '0) && !cfgClash;
  end

endmodule

// File: rtl/bufpool_dp.sv
module bufpool_dp
  import bufpool_pkg::*;
#(
  parameter int NUM_POOLS  = 64,
  parameter int POOL_SLOTS = 16,
  parameter int PTR_W      = 32,
  parameter int REPL_ON    = 4,
  parameter int REPL_OFF   = 8,
  parameter int FLOW_ON    = 2,
  parameter int FLOW_OFF   = 4,
  localparam int POOL_W    = $clog2(NUM_POOLS),
  localparam int CNT_W     = $clog2(POOL_SLOTS + 1),
  localparam int DEPTH     = NUM_POOLS * POOL_SLOTS,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bufpool_strobe_t      stb,
  input  logic [POOL_W-1:0]    opPool,
  input  logic [PTR_W-1:0]     opPtr,
  input  logic [POOL_W-1:0]    cfgPool,
  input  logic [CNT_W-1:0]     cfgCap,
  input  logic [CNT_W-1:0]     cfgReplOn,
  input  logic [CNT_W-1:0]     cfgReplOff,
  input  logic [CNT_W-1:0]     cfgFlowOn,
  input  logic [CNT_W-1:0]     cfgFlowOff,
  output logic [CNT_W-1:0]     selCount,
  output logic [CNT_W-1:0]     selCap,
  output logic [CNT_W-1:0]     cfgCount,
  output logic                 rspValid,
  output logic                 rspIsRelease,
  output logic                 rspOk,
  output logic [POOL_W-1:0]    rspPool,
  output logic [PTR_W-1:0]     rspPtr,
  output logic [NUM_POOLS-1:0] replenish,
  output logic [NUM_POOLS-1:0] flowCtrl
);

  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(POOL_SLOTS);

  logic [CNT_W-1:0] cnt      [NUM_POOLS];
  logic [CNT_W-1:0] cap      [NUM_POOLS];
  logic [CNT_W-1:0] replOn   [NUM_POOLS];
  logic [CNT_W-1:0] replOff  [NUM_POOLS];
  logic [CNT_W-1:0] flowOn   [NUM_POOLS];
  logic [CNT_W-1:0] flowOff  [NUM_POOLS];
  logic [PTR_W-1:0] store    [DEPTH];

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [CNT_W-1:0]  capClamped;

  assign selCount = cnt[opPool];
  assign selCap   = cap[opPool];
  assign cfgCount = cnt[cfgPool];

  // Each pool owns a contiguous stack region of POOL_SLOTS entries.
  assign baseAddr   = ADDR_W'(opPool) * ADDR_W'(POOL_SLOTS);
  assign wrAddr     = baseAddr + ADDR_W'(selCount);
  assign rdAddr     = baseAddr + ADDR_W'(selCount) - ADDR_W'(1);
  assign capClamped = (cfgCap > SLOTS_C) ? SLOTS_C : cfgCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_POOLS; p++) begin
        cnt[p]     <= '0;
        cap[p]     <= SLOTS_C;
        replOn[p]  <= CNT_W'(REPL_ON);
        replOff[p] <= CNT_W'(REPL_OFF);
        flowOn[p]  <= CNT_W'(FLOW_ON);
        flowOff[p] <= CNT_W'(FLOW_OFF);
      end
    end else begin
      if (stb.push) cnt[opPool] <= selCount + CNT_W'(1);
      else if (stb.pop) cnt[opPool] <= selCount - CNT_W'(1);
      if (stb.cfgApply) begin
        cap[cfgPool]     <= capClamped;
        replOn[cfgPool]  <= cfgReplOn;
        replOff[cfgPool] <= cfgReplOff;
        flowOn[cfgPool]  <= cfgFlowOn;
        flowOff[cfgPool] <= cfgFlowOff;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) store[wrAddr] <= opPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspIsRelease <= 1'b0;
      rspOk        <= 1'b0;
      rspPool      <= '0;
      rspPtr       <= '0;
    end else begin
      rspValid     <= stb.opValid;
      rspIsRelease <= stb.isRel;
      rspOk        <= stb.push || stb.pop;
      rspPool      <= opPool;
      rspPtr       <= stb.pop ? store[rdAddr] : '0;
    end
  end

  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    bufpool_hyst #(.CNT_W(CNT_W), .INIT(1'(REPL_ON > 0))) u_repl (
      .clk(clk), .rstN(rstN), .count(cnt[p]),
      .enterLvl(replOn[p]), .exitLvl(replOff[p]), .flag(replenish[p]));
    bufpool_hyst #(.CNT_W(CNT_W), .INIT(1'(FLOW_ON > 0))) u_flow (
      .clk(clk), .rstN(rstN), .count(cnt[p]),
      .enterLvl(flowOn[p]), .exitLvl(flowOff[p]), .flag(flowCtrl[p]));
  end

  // R7: the control never asks for a store and a fetch together
  a_r7_single_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.push, stb.pop}));

  // R3: a fetch is only issued against a pool that holds pointers
  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> (selCount != '0));

  // R4: a store is only issued while the pool has room
  a_r4_push_room: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (selCount < selCap));

  // R9: configuration only lands on an empty pool
  a_r9_cfg_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgApply |-> (cfgCount == '0));

  // R2: every taken request is answered on the next cycle
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    stb.opValid |=> rspValid);

  // R10: no pool ever holds more than its physical slots
  a_r10_cap_bound: assert property (@(posedge clk) disable iff (!rstN)
    selCap <= SLOTS_C);

endmodule

// File: rtl/bufpool_mgr.sv
module bufpool_mgr
  import bufpool_pkg::*;
#(
  parameter int NUM_POOLS  = 64,
  parameter int POOL_SLOTS = 16,
  parameter int PTR_W      = 32,
  parameter int REPL_ON    = 4,
  parameter int REPL_OFF   = 8,
  parameter int FLOW_ON    = 2,
  parameter int FLOW_OFF   = 4,
  localparam int POOL_W    = $clog2(NUM_POOLS),
  localparam int CNT_W     = $clog2(POOL_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 relValid,
  input  logic [POOL_W-1:0]    relPool,
  input  logic [PTR_W-1:0]     relPtr,
  input  logic                 acqValid,
  input  logic [POOL_W-1:0]    acqPool,
  output logic                 acqAccept,
  input  logic                 cfgValid,
  input  logic [POOL_W-1:0]    cfgPool,
  input  logic [CNT_W-1:0]     cfgCap,
  input  logic [CNT_W-1:0]     cfgReplOn,
  input  logic [CNT_W-1:0]     cfgReplOff,
  input  logic [CNT_W-1:0]     cfgFlowOn,
  input  logic [CNT_W-1:0]     cfgFlowOff,
  output logic                 rspValid,
  output logic                 rspIsRelease,
  output logic                 rspOk,
  output logic [POOL_W-1:0]    rspPool,
  output logic [PTR_W-1:0]     rspPtr,
  output logic [NUM_POOLS-1:0] replenish,
  output logic [NUM_POOLS-1:0] flowCtrl
);

  bufpool_strobe_t   stb;
  logic [POOL_W-1:0] opPool;
  logic [PTR_W-1:0]  opPtr;
  logic [CNT_W-1:0]  selCount;
  logic [CNT_W-1:0]  selCap;
  logic [CNT_W-1:0]  cfgCount;

  bufpool_ctrl #(.POOL_W(POOL_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .relValid(relValid), .relPool(relPool), .relPtr(relPtr),
    .acqValid(acqValid), .acqPool(acqPool),
    .cfgValid(cfgValid), .cfgPool(cfgPool),
    .selCount(selCount), .selCap(selCap), .cfgCount(cfgCount),
    .stb(stb), .opPool(opPool), .opPtr(opPtr), .acqAccept(acqAccept));

  bufpool_dp #(
    .NUM_POOLS(NUM_POOLS), .POOL_SLOTS(POOL_SLOTS), .PTR_W(PTR_W),
    .REPL_ON(REPL_ON), .REPL_OFF(REPL_OFF),
    .FLOW_ON(FLOW_ON), .FLOW_OFF(FLOW_OFF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opPool(opPool), .opPtr(opPtr),
    .cfgPool(cfgPool), .cfgCap(cfgCap),
    .cfgReplOn(cfgReplOn), .cfgReplOff(cfgReplOff),
    .cfgFlowOn(cfgFlowOn), .cfgFlowOff(cfgFlowOff),
    .selCount(selCount), .selCap(selCap), .cfgCount(cfgCount),
    .rspValid(rspValid), .rspIsRelease(rspIsRelease), .rspOk(rspOk),
    .rspPool(rspPool), .rspPtr(rspPtr),
    .replenish(replenish), .flowCtrl(flowCtrl));

endmodule

// File: tb/bufpool_mgr_bench.sv
module bufpool_mgr_bench;

  localparam int NP = 64;
  localparam int SL = 16;
  localparam int PW = 32;
  localparam int QW = $clog2(NP);
  localparam int CW = $clog2(SL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic relValid = 1'b0;
  logic [QW-1:0] relPool = '0;
  logic [PW-1:0] relPtr = '0;
  logic acqValid = 1'b0;
  logic [QW-1:0] acqPool = '0;
  logic acqAccept;
  logic cfgValid = 1'b0;
  logic [QW-1:0] cfgPool = '0;
  logic [CW-1:0] cfgCap = '0, cfgReplOn = '0, cfgReplOff = '0;
  logic [CW-1:0] cfgFlowOn = '0, cfgFlowOff = '0;
  logic rspValid, rspIsRelease, rspOk;
  logic [QW-1:0] rspPool;
  logic [PW-1:0] rspPtr;
  logic [NP-1:0] replenish, flowCtrl;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bufpool_mgr u_bufpool_mgr (
    .clk(clk), .rstN(rstN),
    .relValid(relValid), .relPool(relPool), .relPtr(relPtr),
    .acqValid(acqValid), .acqPool(acqPool), .acqAccept(acqAccept),
    .cfgValid(cfgValid), .cfgPool(cfgPool), .cfgCap(cfgCap),
    .cfgReplOn(cfgReplOn), .cfgReplOff(cfgReplOff),
    .cfgFlowOn(cfgFlowOn), .cfgFlowOff(cfgFlowOff),
    .rspValid(rspValid), .rspIsRelease(rspIsRelease), .rspOk(rspOk),
    .rspPool(rspPool), .rspPtr(rspPtr),
    .replenish(replenish), .flowCtrl(flowCtrl));

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doRelease(input int pool, input logic [PW-1:0] ptr,
                           input bit expOk, input string req);
    @(negedge clk);
    relValid = 1'b1; relPool = QW'(pool); relPtr = ptr;
    @(negedge clk);
    relValid = 1'b0;
    check(req, "release rspValid", 64'(rspValid), 64'd1);
    check(req, "release kind", 64'(rspIsRelease), 64'd1);
    check(req, "release ok", 64'(rspOk), 64'(expOk));
    check(req, "release pool", 64'(rspPool), 64'(pool));
  endtask

  task automatic doAcquire(input int pool, input bit expOk,
                           input logic [PW-1:0] expPtr, input string req);
    @(negedge clk);
    acqValid = 1'b1; acqPool = QW'(pool);
    @(negedge clk);
    acqValid = 1'b0;
    check(req, "acquire rspValid", 64'(rspValid), 64'd1);
    check(req, "acquire kind", 64'(rspIsRelease), 64'd0);
    check(req, "acquire ok", 64'(rspOk), 64'(expOk));
    check(req, "acquire ptr", 64'(rspPtr), 64'(expOk ? expPtr : '0));
  endtask

  task automatic checkFlags(input int pool, input bit expRepl, input bit expFlow,
                            input string req);
    @(negedge clk);
    check(req, "replenish flag", 64'(replenish[pool]), 64'(expRepl));
    check(req, "flow flag", 64'(flowCtrl[pool]), 64'(expFlow));
  endtask

  task automatic doConfig(input int pool, input int capV, input int rOn,
                          input int rOff, input int fOn, input int fOff);
    @(negedge clk);
    cfgValid = 1'b1; cfgPool = QW'(pool); cfgCap = CW'(capV);
    cfgReplOn = CW'(rOn); cfgReplOff = CW'(rOff);
    cfgFlowOn = CW'(fOn); cfgFlowOff = CW'(fOff);
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  // R1: reset state
  task automatic testReset();
    @(negedge clk);
    check("R1", "rspValid after reset", 64'(rspValid), 64'd0);
    check("R1", "all replenish high", 64'(replenish), {64{1'b1}});
    check("R1", "all flow high", 64'(flowCtrl), {64{1'b1}});
  endtask

  // R2: pointers return unchanged, newest first
  task automatic testLifo();
    doRelease(1, 32'h0000_0000, 1'b1, "R2");
    doRelease(1, 32'hFFFF_FFFF, 1'b1, "R2");
    doRelease(1, 32'hA5A5_5A5A, 1'b1, "R2");
    doAcquire(1, 1'b1, 32'hA5A5_5A5A, "R2");
    doAcquire(1, 1'b1, 32'hFFFF_FFFF, "R2");
    doAcquire(1, 1'b1, 32'h0000_0000, "R2");
  endtask

  // R3: empty pool acquire fails, count unchanged
  task automatic testEmpty();
    doAcquire(0, 1'b0, '0, "R3");
    checkFlags(0, 1'b1, 1'b1, "R3");
    doRelease(0, 32'h1234_0001, 1'b1, "R3");
    doAcquire(0, 1'b1, 32'h1234_0001, "R3");
    doAcquire(0, 1'b0, '0, "R3");
  endtask

  // R4: full pool drops release
  task automatic testFull();
    doConfig(5, 3, 4, 8, 2, 4);
    for (int i = 0; i < 3; i++) doRelease(5, 32'h5000 + i, 1'b1, "R4");
    doRelease(5, 32'hDEAD_BEEF, 1'b0, "R4");
    doAcquire(5, 1'b1, 32'h5002, "R4");
  endtask

  // R5, R6: hysteresis sweep on a pool with default levels
  task automatic testHysteresis();
    bit expR, expF;
    expR = 1'b1; expF = 1'b1;
    for (int c = 1; c <= 9; c++) begin
      doRelease(3, 32'h300 + c, 1'b1, "R5");
      if (expR && c >= 8) expR = 1'b0;
      if (expF && c >= 4) expF = 1'b0;
      checkFlags(3, expR, expF, "R6");
    end
    for (int c = 8; c >= 0; c--) begin
      doAcquire(3, 1'b1, 32'h300 + c + 1, "R5");
      if (!expR && c < 4) expR = 1'b1;
      if (!expF && c < 2) expF = 1'b1;
      checkFlags(3, expR, expF, "R6");
    end
    // configured levels: replenish enter 0 / exit 1
    doConfig(8, 16, 0, 1, 2, 4);
    checkFlags(8, 1'b1, 1'b1, "R5");
    doRelease(8, 32'h8, 1'b1, "R5");
    checkFlags(8, 1'b0, 1'b1, "R5");
    doAcquire(8, 1'b1, 32'h8, "R5");
    checkFlags(8, 1'b0, 1'b1, "R5");
  endtask

  // R7: release wins over acquire in the same cycle
  task automatic testCollision();
    doRelease(10, 32'hC0FF_EE00, 1'b1, "R7");
    @(negedge clk);
    relValid = 1'b1; relPool = QW'(9); relPtr = 32'h9999;
    acqValid = 1'b1; acqPool = QW'(10);
    #1;
    check("R7", "acqAccept during release", 64'(acqAccept), 64'd0);
    @(negedge clk);
    relValid = 1'b0; acqValid = 1'b0;
    check("R7", "served kind", 64'(rspIsRelease), 64'd1);
    check("R7", "served pool", 64'(rspPool), 64'd9);
    @(negedge clk);
    check("R7", "no acquire response", 64'(rspValid), 64'd0);
    doAcquire(10, 1'b1, 32'hC0FF_EE00, "R7");
    doAcquire(10, 1'b0, '0, "R7");
  endtask

  // R8: pools are independent
  task automatic testIndependent();
    for (int i = 0; i < 5; i++) doRelease(11, 32'hB00 + i, 1'b1, "R8");
    checkFlags(11, 1'b1, 1'b0, "R8");
    checkFlags(12, 1'b1, 1'b1, "R8");
    doAcquire(12, 1'b0, '0, "R8");
  endtask

  // R9: config ignored on a non-empty pool
  task automatic testCfgGate();
    doRelease(7, 32'h7001, 1'b1, "R9");
    doConfig(7, 1, 4, 8, 2, 4);
    doRelease(7, 32'h7002, 1'b1, "R9");
    doAcquire(7, 1'b1, 32'h7002, "R9");
  endtask

  // R10: oversize capacity is clamped
  task automatic testClamp();
    doConfig(6, 31, 4, 8, 2, 4);
    for (int i = 0; i < SL; i++) doRelease(6, 32'h6000 + i, 1'b1, "R10");
    doRelease(6, 32'h6FFF, 1'b0, "R10");
    doAcquire(6, 1'b1, 32'h6000 + SL - 1, "R10");
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLifo();
    testEmpty();
    testFull();
    testHysteresis();
    testCollision();
    testIndependent();
    testCfgGate();
    testClamp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule